// File: doc/BRIEF.md
# Flash Controller Register Interface

This block is the software-visible register front end of an embedded flash controller. It sits on a plain 32-bit register bus (byte offset, write strobe, write data, read strobe, registered read data) and holds six registers in a 1 KB window. Software uses it to set the access timing fields (wait states, prefetch, instruction and data cache enables), which leave the block as output pins. It also reads the operation status flags and edits the program/erase control and option-byte control registers.

The control and option registers are each guarded by their own two-word key sequence. Each guard is a separate small state machine. A key written in the wrong step locks that register and leaves its sequence stuck until the next reset. Writing the register's lock bit relocks it on demand. Status flags are raised by event pulses from the flash engine and are all cleared by any write to the status register. The flash engine itself (programming, erase timing, the array, interrupts) lies outside this block.

Top module: `flash_regif`

## Requirements
- R1: After reset the access register reads 0x00000000, status 0x00000000, control 0x80000000 (bit 31 is its lock bit, set) and option control 0x0FFFAAED (bit 0 is its lock bit, set); `ctrl_locked` and `opt_locked` are 1.
- R2: A read strobe in cycle N puts the value of the addressed register, as it stood at that edge, on `bus_rdata` in cycle N+1; in a cycle after no read strobe `bus_rdata` is 0.
- R3: Writing 0x45670123 and then 0xCDEF89AB to offset 0x04 clears the control lock bit, and the sequence returns to its first step.
- R4: Writing 0x08192A3B and then 0x4C5D6E7F to offset 0x08 clears the option lock bit, and that sequence returns to its first step; the two sequences are independent.
- R5: A key word that does not match the word expected at the current step (including a correct word in the wrong order) sets that register's lock bit and makes its sequence stuck: no later key write unlocks it until reset, and after reset the sequence works again.
- R6: A write with the lock bit set (control bit 31, option bit 0) relocks the register, leaves its other fields unchanged, and returns a non-stuck key sequence to its first step, so that a half-entered sequence is abandoned.
- R7: Offset 0x00 stores wait states in bits [2:0], prefetch enable in bit 8, instruction cache enable in bit 9 and data cache enable in bit 10, drives them onto `wait_states`, `prefetch_en`, `icache_en` and `dcache_en`, and reads all other bits as 0.
- R8: While a guarded register is locked, writes with its lock bit clear change nothing. While it is unlocked, such a write loads the writable fields: control mask 0x0101037F, option mask 0x0FFFFFEE.
- R9: `evt_flag[5:0]` pulses set status bits 0, 1, 4, 5, 6, 7 respectively. Any write to offset 0x0C clears all flags, and an event in the same cycle as the clearing write still leaves its flag set.
- R10: The key offsets 0x04 and 0x08, and any unmapped or misaligned offset, read as 0; writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 10 | Byte offset inside the register window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| evt_flag | input | 6 | Status event pulses from the flash engine |
| wait_states | output | 3 | Flash access wait states |
| prefetch_en | output | 1 | Prefetch enable |
| icache_en | output | 1 | Instruction cache enable |
| dcache_en | output | 1 | Data cache enable |
| ctrl_locked | output | 1 | Control register lock state |
| opt_locked | output | 1 | Option register lock state |

## Verification
Every write takes effect at the edge where the strobe is sampled. The lock pins, access-field pins and register contents therefore change one cycle after the write, while read data appears one cycle after its read strobe. The bench drives strobes on the falling edge for exactly one cycle. Its scoreboard monitor records at the next rising edge that a read was issued and compares `bus_rdata` on the following falling edge against the head of the expected queue. Pin checks are made on a falling edge after the write strobe has been sampled, so every comparison falls half a cycle after the register it observes was updated.

// File: rtl/flash_regif_pkg.sv
package flash_regif_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_FLAGS = 6;

    // Register byte offsets
    localparam logic [9:0] OFF_ACCESS = 10'h000;
    localparam logic [9:0] OFF_CKEY   = 10'h004;
    localparam logic [9:0] OFF_OKEY   = 10'h008;
    localparam logic [9:0] OFF_STATUS = 10'h00C;
    localparam logic [9:0] OFF_CTRL   = 10'h010;
    localparam logic [9:0] OFF_OPTION = 10'h014;

    // Key words
    localparam logic [DATA_W-1:0] CTRL_KEY_A = 32'h4567_0123;
    localparam logic [DATA_W-1:0] CTRL_KEY_B = 32'hCDEF_89AB;
    localparam logic [DATA_W-1:0] OPT_KEY_A  = 32'h0819_2A3B;
    localparam logic [DATA_W-1:0] OPT_KEY_B  = 32'h4C5D_6E7F;

    // Field layouts
    localparam logic [DATA_W-1:0] ACCESS_MASK = 32'h0000_0707;
    localparam logic [DATA_W-1:0] CTRL_MASK   = 32'h0101_037F;
    localparam logic [DATA_W-1:0] OPT_MASK    = 32'h0FFF_FFEE;
    localparam logic [DATA_W-1:0] CTRL_RST    = 32'h8000_0000;
    localparam logic [DATA_W-1:0] OPT_RST     = 32'h0FFF_AAED;
    localparam int                CTRL_LOCK_BIT = 31;
    localparam int                OPT_LOCK_BIT  = 0;

    typedef enum logic [1:0] {
        KS_FIRST  = 2'd0,
        KS_SECOND = 2'd1,
        KS_STUCK  = 2'd2
    } key_step_e;

    // Spread compact status flags onto their register bit positions
    function automatic logic [DATA_W-1:0] stat_spread(input logic [NUM_FLAGS-1:0] f);
        logic [DATA_W-1:0] r;
        r      = '0;
        r[0]   = f[0];
        r[1]   = f[1];
        r[7:4] = f[5:2];
        return r;
    endfunction

endpackage

// File: rtl/flash_key_seq.sv
module flash_key_seq
    import flash_regif_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEY_A = 32'h0,
    parameter logic [DATA_W-1:0] KEY_B = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_we,
    input  logic [DATA_W-1:0] key_wdata,
    input  logic              relock_req,
    output logic              locked
);

    typedef struct packed {
        key_step_e step;
        logic      lock;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (key_we) begin
            unique case (st_q.step)
                KS_FIRST: begin
                    if (key_wdata == KEY_A) begin
                        st_d.step = KS_SECOND;
                    end else begin
                        st_d.step = KS_STUCK;
                        st_d.lock = 1'b1;
                    end
                end
                KS_SECOND: begin
                    if (key_wdata == KEY_B) begin
                        st_d.step = KS_FIRST;
                        st_d.lock = 1'b0;
                    end else begin
                        st_d.step = KS_STUCK;
                        st_d.lock = 1'b1;
                    end
                end
                default: begin
                    st_d.step = KS_STUCK;
                    st_d.lock = 1'b1;
                end
            endcase
        end else if (relock_req) begin
            st_d.lock = 1'b1;
            if (st_q.step != KS_STUCK) begin
                st_d.step = KS_FIRST;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{step: KS_FIRST, lock: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.lock;

    AST_UNLOCK_NEEDS_KEY_B: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.lock) |-> $past(key_we && key_wdata == KEY_B && st_q.step == KS_SECOND)); // R3
    AST_STUCK_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.step == KS_STUCK) |=> (st_q.lock && st_q.step == KS_STUCK)); // R5
    AST_RELOCK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (relock_req && !key_we) |=> st_q.lock); // R6

endmodule

// File: rtl/flash_guarded_reg.sv
module flash_guarded_reg
    import flash_regif_pkg::*;
#(
    parameter logic [DATA_W-1:0] FIELD_MASK = 32'h0,
    parameter logic [DATA_W-1:0] RST_VALUE  = 32'h0,
    parameter int                LOCK_BIT   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              locked,
    output logic [DATA_W-1:0] reg_value
);

    localparam logic [DATA_W-1:0] FIELD_RST = RST_VALUE & FIELD_MASK;

    typedef struct packed {
        logic [DATA_W-1:0] fields;
    } guard_state_t;

    guard_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reg_we && !locked && !reg_wdata[LOCK_BIT]) begin
            st_d.fields = reg_wdata & FIELD_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{fields: FIELD_RST};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_value           = st_q.fields;
        reg_value[LOCK_BIT] = locked;
    end

    AST_LOCKED_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(st_q.fields)); // R8

endmodule

// File: rtl/flash_stat.sv
module flash_stat
    import flash_regif_pkg::*;
#(
    parameter int NFLAG = NUM_FLAGS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] ev_set,
    input  logic             clr_all,
    output logic [NFLAG-1:0] flags
);

    typedef struct packed {
        logic [NFLAG-1:0] flg;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NFLAG; i++) begin
            st_d.flg[i] = ev_set[i] | (st_q.flg[i] & !clr_all);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{flg: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flg;

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && ev_set == '0) |=> (flags == '0)); // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_set != '0) |=> ((flags & $past(ev_set)) == $past(ev_set))); // R9

endmodule

// File: rtl/flash_regif.sv
module flash_regif
    import flash_regif_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    input  logic [5:0]        evt_flag,
    output logic [2:0]        wait_states,
    output logic              prefetch_en,
    output logic              icache_en,
    output logic              dcache_en,
    output logic              ctrl_locked,
    output logic              opt_locked
);

    localparam logic [ADDR_W-1:0] A_ACCESS = ADDR_W'(OFF_ACCESS);
    localparam logic [ADDR_W-1:0] A_CKEY   = ADDR_W'(OFF_CKEY);
    localparam logic [ADDR_W-1:0] A_OKEY   = ADDR_W'(OFF_OKEY);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_OPTION = ADDR_W'(OFF_OPTION);

    // Address decode
    logic sel_access, sel_ckey, sel_okey, sel_status, sel_ctrl, sel_option, sel_none;
    always_comb begin
        sel_access = (bus_addr == A_ACCESS);
        sel_ckey   = (bus_addr == A_CKEY);
        sel_okey   = (bus_addr == A_OKEY);
        sel_status = (bus_addr == A_STATUS);
        sel_ctrl   = (bus_addr == A_CTRL);
        sel_option = (bus_addr == A_OPTION);
        sel_none   = !(sel_access | sel_ckey | sel_okey | sel_status | sel_ctrl | sel_option);
    end

    // Guarded registers and their key sequences
    logic              ctrl_lock_w, opt_lock_w;
    logic [DATA_W-1:0] ctrl_value, opt_value;
    logic [NUM_FLAGS-1:0] stat_flags;

    flash_key_seq #(.KEY_A(CTRL_KEY_A), .KEY_B(CTRL_KEY_B)) u_ctrl_keys (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_we     (bus_we && sel_ckey),
        .key_wdata  (bus_wdata),
        .relock_req (bus_we && sel_ctrl && bus_wdata[CTRL_LOCK_BIT]),
        .locked     (ctrl_lock_w)
    );

    flash_key_seq #(.KEY_A(OPT_KEY_A), .KEY_B(OPT_KEY_B)) u_opt_keys (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_we     (bus_we && sel_okey),
        .key_wdata  (bus_wdata),
        .relock_req (bus_we && sel_option && bus_wdata[OPT_LOCK_BIT]),
        .locked     (opt_lock_w)
    );

    flash_guarded_reg #(.FIELD_MASK(CTRL_MASK), .RST_VALUE(CTRL_RST), .LOCK_BIT(CTRL_LOCK_BIT)) u_ctrl_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (bus_we && sel_ctrl),
        .reg_wdata (bus_wdata),
        .locked    (ctrl_lock_w),
        .reg_value (ctrl_value)
    );

    flash_guarded_reg #(.FIELD_MASK(OPT_MASK), .RST_VALUE(OPT_RST), .LOCK_BIT(OPT_LOCK_BIT)) u_opt_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (bus_we && sel_option),
        .reg_wdata (bus_wdata),
        .locked    (opt_lock_w),
        .reg_value (opt_value)
    );

    flash_stat #(.NFLAG(NUM_FLAGS)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_set  (evt_flag),
        .clr_all (bus_we && sel_status),
        .flags   (stat_flags)
    );

    // Access register and read data
    typedef struct packed {
        logic [DATA_W-1:0] access;
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (bus_we && sel_access) begin
            st_d.access = bus_wdata & ACCESS_MASK;
        end
        if (bus_re) begin
            unique case (1'b1)
                sel_access: st_d.rdata = st_q.access;
                sel_status: st_d.rdata = stat_spread(stat_flags);
                sel_ctrl:   st_d.rdata = ctrl_value;
                sel_option: st_d.rdata = opt_value;
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{access: '0, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata   = st_q.rdata;
    assign wait_states = st_q.access[2:0];
    assign prefetch_en = st_q.access[8];
    assign icache_en   = st_q.access[9];
    assign dcache_en   = st_q.access[10];
    assign ctrl_locked = ctrl_lock_w;
    assign opt_locked  = opt_lock_w;

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (bus_rdata == '0)); // R2
    AST_KEY_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && (sel_none || sel_ckey || sel_okey)) |=> (bus_rdata == '0)); // R10
    AST_ACCESS_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && sel_access) |=> ((bus_rdata & ~ACCESS_MASK) == '0)); // R7

endmodule

// File: tb/flash_regif_bench.sv
`timescale 1ns/1ps
module flash_regif_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [5:0]  evt_flag = '0;
    logic [2:0]  wait_states;
    logic        prefetch_en, icache_en, dcache_en, ctrl_locked, opt_locked;

    always #2.5 clk = ~clk;

    flash_regif u_flash_regif (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .evt_flag(evt_flag), .wait_states(wait_states), .prefetch_en(prefetch_en),
        .icache_en(icache_en), .dcache_en(dcache_en),
        .ctrl_locked(ctrl_locked), .opt_locked(opt_locked)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference model
    logic [31:0] m_acc, m_stat, m_ctrl, m_opt;
    int          m_cstep, m_ostep;   // 0 first, 1 second, 2 stuck

    // Scoreboard
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always @(posedge clk) rd_seen <= bus_re;

    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (bus_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [9:0] a);
        case (a)
            10'h000: return m_acc;
            10'h00C: return m_stat;
            10'h010: return m_ctrl;
            10'h014: return m_opt;
            default: return 32'h0;
        endcase
    endfunction

    task automatic key_step(inout int step, inout logic lk, input logic [31:0] d,
                            input logic [31:0] ka, input logic [31:0] kb);
        if (step == 0 && d == ka) step = 1;
        else if (step == 1 && d == kb) begin step = 0; lk = 1'b0; end
        else begin step = 2; lk = 1'b1; end
    endtask

    task automatic model_write(input logic [9:0] a, input logic [31:0] d);
        logic lk;
        case (a)
            10'h000: m_acc = d & 32'h0000_0707;
            10'h004: begin lk = m_ctrl[31]; key_step(m_cstep, lk, d, 32'h4567_0123, 32'hCDEF_89AB); m_ctrl[31] = lk; end
            10'h008: begin lk = m_opt[0];   key_step(m_ostep, lk, d, 32'h0819_2A3B, 32'h4C5D_6E7F); m_opt[0] = lk; end
            10'h00C: m_stat = 32'h0;
            10'h010: begin
                if (d[31]) begin m_ctrl[31] = 1'b1; if (m_cstep != 2) m_cstep = 0; end
                else if (!m_ctrl[31]) m_ctrl = d & 32'h0101_037F;
            end
            10'h014: begin
                if (d[0]) begin m_opt[0] = 1'b1; if (m_ostep != 2) m_ostep = 0; end
                else if (!m_opt[0]) m_opt = d & 32'h0FFF_FFEE;
            end
            default: ;
        endcase
    endtask

    task automatic model_reset();
        m_acc = 0; m_stat = 0; m_ctrl = 32'h8000_0000; m_opt = 32'h0FFF_AAED;
        m_cstep = 0; m_ostep = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(input logic [9:0] a, input string t);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        exp_q.push_back(model_read(a));
        tag_q.push_back(t);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    function automatic logic [31:0] spread(input logic [5:0] f);
        return {24'h0, f[5], f[4], f[3], f[2], 2'b00, f[1], f[0]};
    endfunction

    task automatic pulse(input logic [5:0] f, input bit with_clear);
        @(negedge clk);
        evt_flag = f;
        if (with_clear) begin bus_addr = 10'h00C; bus_we = 1'b1; bus_wdata = 32'h0; end
        @(negedge clk);
        evt_flag = '0; bus_we = 1'b0;
        if (with_clear) m_stat = 32'h0;
        m_stat = m_stat | spread(f);
    endtask

    task automatic check_pins(input string t);
        check({t, " ctrl_locked"}, {31'h0, ctrl_locked}, {31'h0, m_ctrl[31]});
        check({t, " opt_locked"},  {31'h0, opt_locked},  {31'h0, m_opt[0]});
        check({t, " access pins"}, {21'h0, dcache_en, icache_en, prefetch_en, 5'h0, wait_states},
              m_acc);
    endtask

    task automatic read_all(input string t);
        rd(10'h000, {t, " access"});
        rd(10'h00C, {t, " status"});
        rd(10'h010, {t, " ctrl"});
        rd(10'h014, {t, " option"});
    endtask

    initial begin
        model_reset();
        do_reset();

        // R1 reset state
        check("R1 ctrl reset model", m_ctrl, 32'h8000_0000);
        read_all("R1");
        check_pins("R1");
        // R10 key and unmapped reads
        rd(10'h004, "R10 ctrl key read");
        rd(10'h008, "R10 opt key read");
        rd(10'h3FC, "R10 unmapped read");
        rd(10'h011, "R10 misaligned read");
        wr(10'h200, 32'hFFFF_FFFF);
        read_all("R10 after unmapped write");
        // R2 no read strobe -> zero
        @(negedge clk); @(negedge clk);
        check("R2 idle rdata", bus_rdata, 32'h0);

        // R7 access fields
        wr(10'h000, 32'hFFFF_FFFF);
        rd(10'h000, "R7 access all ones");
        check_pins("R7 all ones");
        wr(10'h000, 32'h0000_0105);
        rd(10'h000, "R7 access 0x105");
        check_pins("R7 0x105");

        // R8 locked control ignores field writes
        wr(10'h010, 32'h0000_0001);
        rd(10'h010, "R8 ctrl locked write ignored");

        // R3 control unlock
        wr(10'h004, 32'h4567_0123);
        check("R3 still locked after first key", {31'h0, ctrl_locked}, 32'h1);
        wr(10'h004, 32'hCDEF_89AB);
        check_pins("R3 unlocked");
        rd(10'h010, "R3 ctrl unlocked");
        // R8 unlocked load
        wr(10'h010, 32'h7FFF_FFFF);
        rd(10'h010, "R8 ctrl fields load");
        // R6 relock keeps fields
        wr(10'h010, 32'h8000_0000);
        rd(10'h010, "R6 ctrl relock");
        check_pins("R6 ctrl relock");
        // R3 sequence returned to start: unlock again
        wr(10'h004, 32'h4567_0123);
        wr(10'h004, 32'hCDEF_89AB);
        rd(10'h010, "R3 ctrl second unlock");
        wr(10'h010, 32'h8000_0000);
        // R6 half sequence abandoned by relock
        wr(10'h004, 32'h4567_0123);
        wr(10'h010, 32'h8000_0000);
        wr(10'h004, 32'hCDEF_89AB);
        check("R6 half sequence abandoned", {31'h0, ctrl_locked}, 32'h1);
        // R5 stuck
        wr(10'h004, 32'h4567_0123);
        wr(10'h004, 32'hCDEF_89AB);
        check("R5 ctrl stuck", {31'h0, ctrl_locked}, 32'h1);
        wr(10'h010, 32'h8000_0000);
        wr(10'h004, 32'h4567_0123);
        wr(10'h004, 32'hCDEF_89AB);
        check("R5 ctrl stuck after relock", {31'h0, ctrl_locked}, 32'h1);
        rd(10'h010, "R5 ctrl stuck read");

        // R4 option unlock, independent of control
        wr(10'h008, 32'h0819_2A3B);
        wr(10'h008, 32'h4C5D_6E7F);
        check_pins("R4 opt unlocked");
        wr(10'h014, 32'hFFFF_FFFE);
        rd(10'h014, "R8 opt fields load");
        wr(10'h014, 32'h0000_0001);
        rd(10'h014, "R6 opt relock");
        wr(10'h014, 32'h0000_0000);
        rd(10'h014, "R8 opt locked write ignored");
        // R5 option wrong second key
        wr(10'h008, 32'h0819_2A3B);
        wr(10'h008, 32'h1234_5678);
        wr(10'h008, 32'h0819_2A3B);
        wr(10'h008, 32'h4C5D_6E7F);
        check_pins("R5 opt stuck");

        // R9 status flags
        pulse(6'b000001, 1'b0);
        rd(10'h00C, "R9 done flag");
        pulse(6'b111110, 1'b0);
        rd(10'h00C, "R9 error flags");
        wr(10'h00C, 32'h0);
        rd(10'h00C, "R9 cleared");
        pulse(6'b111111, 1'b0);
        pulse(6'b010100, 1'b1);
        rd(10'h00C, "R9 set wins over clear");

        // R5 reset restores sequences
        do_reset();
        read_all("R1 after second reset");
        wr(10'h004, 32'h4567_0123);
        wr(10'h004, 32'hCDEF_89AB);
        wr(10'h008, 32'h0819_2A3B);
        wr(10'h008, 32'h4C5D_6E7F);
        check_pins("R5 unlock after reset");

        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule